// File: doc/BRIEF.md
# Min-Max Check Node Update Unit

This block computes the outgoing messages of one parity check node in an LDPC decoder that works in the binary min-max domain. In this domain each message is an unsigned cost, and combining messages takes a maximum rather than a sum, which is cheaper in hardware than belief propagation on log-likelihood ratios. The node has six edges. A start pulse loads six incoming costs at once, and the block holds them internally while it works.

For each outgoing edge, taken in ascending order from edge 0, the block walks through every bit pattern of the five other edges, one pattern per clock. A pattern counts only when an odd number of its bits are set. Its score is the largest cost among the edges whose bit is 1. The outgoing message is the smallest score found, and the running minimum starts at the all-ones value. Each message leaves on a stream together with its edge index. A single-cycle done pulse follows the last message. The message memories, the routing of the parity-check matrix and the variable node update sit outside this block.

Top module: `mm_min_max_cnu`

## Requirements
- R1: After reset, busy_o, msg_valid_o and done_o are 0.
- R2: A start_i sampled high while busy_o is 0 is accepted, and busy_o is 1 from the next cycle. The six costs (edge k in cost_i bits [6k+5:6k]) are captured at that edge, so later changes on cost_i do not affect the results.
- R3: A start_i sampled while busy_o is 1 is ignored. The pattern walk continues, and every message comes from the costs captured at acceptance.
- R4: Messages come out in edge order 0, 1, 2, 3, 4, 5, one per edge, and msg_edge_o carries the edge index in binary.
- R5: The message for edge e is valid for one cycle only, in the cycle that follows clock edge 32*(e+1) counted after the accepting edge. All 32 patterns are visited for every edge, the rejected ones included.
- R6: The message for edge e is the minimum, taken over the odd-weight patterns of the other five edges, of the maximum cost among the set positions. This equals the smallest of the five other costs.
- R7: Patterns of even weight, the empty pattern among them, never contribute. When all costs are nonzero, no message is 0.
- R8: Messages are 6 bits wide and saturate at all-ones. With every cost at 63, every message is 63.
- R9: done_o is high for exactly one cycle, in the cycle after the edge-5 message is valid. busy_o is already 0 while the edge-5 message is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; the costs are valid with it |
| cost_i | input | 36 | Six incoming costs, edge k in bits [6k+5:6k] |
| busy_o | output | 1 | Node update in progress |
| msg_valid_o | output | 1 | Outgoing message valid |
| msg_edge_o | output | 3 | Edge index of the outgoing message |
| msg_o | output | 6 | Outgoing check-to-variable cost |
| done_o | output | 1 | One-cycle pulse after the last message |

## Verification
The bench builds the block with its default degree of six and cost width of six bits. With these values each node takes under two hundred cycles, so the bench can run a fixed set of corner vectors, a sweep that places a unique minimum on every edge, and a long run of pseudo-random cost sets. Each result is compared with the closed form for the minimum of the other five costs. That form reaches every placement of the minimum relative to the skipped edge. It also exposes any error in the parity rule, because an even-weight pattern such as the empty one would pull a message down to 0. Each message is also checked at its exact cycle, and further runs drive a restart during a sweep and scramble the inputs after acceptance.

// File: rtl/mm_cn_pkg.sv
package mm_cn_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_SWEEP = 1'b1} cn_phase_e;
endpackage

// File: rtl/mm_cn_walker.sv
module mm_cn_walker
  import mm_cn_pkg::*;
#(
  parameter int DEG = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  output logic                       accept_o,
  output logic                       busy_o,
  output logic [DEG-2:0]             cfg_o,
  output logic [$clog2(DEG)-1:0]     edge_o,
  output logic                       cfg_last_o,
  output logic                       edge_last_o
);
  localparam int CFG_W  = DEG - 1;
  localparam int EIDX_W = $clog2(DEG);

  cn_phase_e         phase_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [EIDX_W-1:0] edge_q;

  assign accept_o    = start_i && (phase_q == PH_IDLE);
  assign busy_o      = (phase_q == PH_SWEEP);
  assign cfg_last_o  = busy_o && (&cfg_q);
  assign edge_last_o = (edge_q == EIDX_W'(DEG - 1));
  assign cfg_o       = cfg_q;
  assign edge_o      = edge_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cfg_q   <= '0;
      edge_q  <= '0;
    end else if (accept_o) begin
      phase_q <= PH_SWEEP;
      cfg_q   <= '0;
      edge_q  <= '0;
    end else if (phase_q == PH_SWEEP) begin
      cfg_q <= cfg_q + 1'b1;
      if (cfg_last_o) begin
        if (edge_last_o) phase_q <= PH_IDLE;
        else             edge_q  <= edge_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mm_cn_score.sv
module mm_cn_score #(
  parameter int DEG = 6,
  parameter int W   = 6
) (
  input  logic [DEG*W-1:0]           costs_i,
  input  logic [$clog2(DEG)-1:0]     edge_i,
  input  logic [DEG-2:0]             cfg_i,
  output logic                       odd_o,
  output logic [W-1:0]               score_o
);
  localparam int CFG_W = DEG - 1;

  logic [W-1:0] other [CFG_W];

  function automatic logic odd_weight(input logic [CFG_W-1:0] v);
    return ^v;
  endfunction

  function automatic logic [W-1:0] larger(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  // Pattern bit j stands for the j-th edge after skipping the target edge.
  for (genvar j = 0; j < CFG_W; j++) begin : g_other
    assign other[j] = (j < int'(edge_i)) ? costs_i[j*W +: W] : costs_i[(j+1)*W +: W];
  end

  always_comb begin
    score_o = '0;
    for (int j = 0; j < CFG_W; j++) begin
      if (cfg_i[j]) score_o = larger(score_o, other[j]);
    end
  end

  assign odd_o = odd_weight(cfg_i);
endmodule

// File: rtl/mm_cn_minacc.sv
module mm_cn_minacc #(
  parameter int DEG = 6,
  parameter int W   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept_i,
  input  logic                       step_i,
  input  logic                       odd_i,
  input  logic [W-1:0]               score_i,
  input  logic                       cfg_last_i,
  input  logic [$clog2(DEG)-1:0]     edge_i,
  output logic [W-1:0]               run_min_o,
  output logic                       msg_valid_o,
  output logic [$clog2(DEG)-1:0]     msg_edge_o,
  output logic [W-1:0]               msg_o,
  output logic                       done_o
);
  localparam int          EIDX_W = $clog2(DEG);
  localparam logic [W-1:0] SAT   = '1;

  logic [W-1:0] run_q, cand, next_min;

  function automatic logic [W-1:0] smaller(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  assign cand      = odd_i ? score_i : SAT;
  assign next_min  = smaller(run_q, cand);
  assign run_min_o = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= SAT;
      msg_valid_o <= 1'b0;
      msg_edge_o  <= '0;
      msg_o       <= '0;
      done_o      <= 1'b0;
    end else begin
      msg_valid_o <= step_i && cfg_last_i;
      done_o      <= msg_valid_o && (msg_edge_o == EIDX_W'(DEG - 1));
      if (accept_i) begin
        run_q <= SAT;
      end else if (step_i) begin
        run_q <= cfg_last_i ? SAT : next_min;
      end
      if (step_i && cfg_last_i) begin
        msg_o      <= next_min;
        msg_edge_o <= edge_i;
      end
    end
  end
endmodule

// File: rtl/mm_min_max_cnu.sv
module mm_min_max_cnu #(
  parameter int DEG = 6,
  parameter int W   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [DEG*W-1:0]           cost_i,
  output logic                       busy_o,
  output logic                       msg_valid_o,
  output logic [$clog2(DEG)-1:0]     msg_edge_o,
  output logic [W-1:0]               msg_o,
  output logic                       done_o
);
  localparam int CFG_W  = DEG - 1;
  localparam int EIDX_W = $clog2(DEG);

  logic [DEG*W-1:0]  costs_q;
  logic              accept_w, cfg_last_w, edge_last_w, odd_w;
  logic [CFG_W-1:0]  cfg_w;
  logic [EIDX_W-1:0] edge_w;
  logic [W-1:0]      score_w, run_min_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        costs_q <= '0;
    else if (accept_w) costs_q <= cost_i;
  end

  mm_cn_walker #(.DEG(DEG)) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .accept_o    (accept_w),
    .busy_o      (busy_o),
    .cfg_o       (cfg_w),
    .edge_o      (edge_w),
    .cfg_last_o  (cfg_last_w),
    .edge_last_o (edge_last_w)
  );

  mm_cn_score #(.DEG(DEG), .W(W)) u_score (
    .costs_i (costs_q),
    .edge_i  (edge_w),
    .cfg_i   (cfg_w),
    .odd_o   (odd_w),
    .score_o (score_w)
  );

  mm_cn_minacc #(.DEG(DEG), .W(W)) u_minacc (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept_w),
    .step_i      (busy_o),
    .odd_i       (odd_w),
    .score_i     (score_w),
    .cfg_last_i  (cfg_last_w),
    .edge_i      (edge_w),
    .run_min_o   (run_min_w),
    .msg_valid_o (msg_valid_o),
    .msg_edge_o  (msg_edge_o),
    .msg_o       (msg_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/mm_cn_checker.sv
module mm_cn_checker #(
  parameter int DEG = 6,
  parameter int W   = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic                   busy_o,
  input logic                   msg_valid_o,
  input logic [$clog2(DEG)-1:0] msg_edge_o,
  input logic                   done_o,
  input logic [DEG-2:0]         cfg_w,
  input logic [$clog2(DEG)-1:0] edge_w,
  input logic [W-1:0]           run_min_w
);
  a_r2_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o && cfg_w == '0 && edge_w == '0);

  a_r3_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !(&cfg_w) |=> cfg_w == $past(cfg_w) + 1'b1 && edge_w == $past(edge_w));

  a_r4_edge_range: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> int'(msg_edge_o) < DEG);

  a_r5_msg_after_last_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> $past(busy_o) && (&$past(cfg_w)));

  a_r5_msg_single: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |=> !msg_valid_o);

  a_r6_min_nonincreasing: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && cfg_w != '0 |-> run_min_w <= $past(run_min_w));

  a_r9_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && int'(msg_edge_o) == DEG - 1 |=> done_o);

  a_r9_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(msg_valid_o) && int'($past(msg_edge_o)) == DEG - 1);

  a_r9_idle_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && int'(msg_edge_o) == DEG - 1 |-> !busy_o);
endmodule

bind mm_min_max_cnu mm_cn_checker #(.DEG(DEG), .W(W)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .msg_valid_o (msg_valid_o),
  .msg_edge_o  (msg_edge_o),
  .done_o      (done_o),
  .cfg_w       (cfg_w),
  .edge_w      (edge_w),
  .run_min_w   (run_min_w)
);

// File: tb/test_mm_min_max_cnu.sv
module test_mm_min_max_cnu;
  localparam int CLK_PERIOD = 10;
  localparam int DEG = 6;
  localparam int W   = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [DEG*W-1:0] cost_i = '0;
  logic             busy_o, msg_valid_o, done_o;
  logic [2:0]       msg_edge_o;
  logic [W-1:0]     msg_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_min_max_cnu #(.DEG(DEG), .W(W)) i_mm_min_max_cnu (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .cost_i (cost_i),
    .busy_o (busy_o), .msg_valid_o (msg_valid_o), .msg_edge_o (msg_edge_o),
    .msg_o (msg_o), .done_o (done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Closed form of the min-max rule: the smallest cost among the other edges.
  function automatic int min_other(input logic [DEG*W-1:0] c, input int e);
    int m = (1 << W) - 1;
    for (int k = 0; k < DEG; k++)
      if (k != e && int'(c[k*W +: W]) < m) m = int'(c[k*W +: W]);
    return m;
  endfunction

  task automatic run_node(input logic [DEG*W-1:0] c, input bit scramble, input bit restart);
    int exp_e = 0;
    @(negedge clk);
    cost_i  = c;
    start_i = 1'b1;
    @(posedge clk);
    for (int n = 0; n <= 194; n++) begin
      @(negedge clk);
      if (n == 0) begin
        start_i = 1'b0;
        if (scramble) cost_i = ~c;
      end
      if (restart && n == 50) begin
        start_i = 1'b1;
        cost_i  = {DEG{6'd1}};
      end
      if (restart && n == 51) start_i = 1'b0;
      if (n == 1) chk(busy_o == 1'b1, "R2 busy after accept", int'(busy_o), 1);
      if (msg_valid_o) begin
        chk(n == 32 * (exp_e + 1), "R5 message cycle", n, 32 * (exp_e + 1));
        chk(int'(msg_edge_o) == exp_e, "R4 edge order", int'(msg_edge_o), exp_e);
        chk(int'(msg_o) == min_other(c, exp_e),
            (scramble || restart) ? "R2/R3 captured costs used" : "R6 min-max value",
            int'(msg_o), min_other(c, exp_e));
        exp_e++;
      end
      if (n == 192) chk(busy_o == 1'b0, "R9 idle at last message", int'(busy_o), 0);
      if (n == 193) chk(done_o == 1'b1, "R9 done after last", int'(done_o), 1);
      else if (done_o) chk(1'b0, "R9 done single cycle", n, 193);
    end
    chk(exp_e == DEG, "R4 message count", exp_e, DEG);
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DEG*W-1:0] c;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && msg_valid_o == 1'b0 && done_o == 1'b0,
        "R1 reset state", int'({busy_o, msg_valid_o, done_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0, "R1 idle after reset", int'(busy_o), 0);

    // R8: saturation with every cost at all-ones
    run_node({DEG{6'd63}}, 1'b0, 1'b0);
    // R7: equal nonzero costs, an even-weight pattern would give 0
    run_node({DEG{6'd20}}, 1'b0, 1'b0);
    run_node({DEG{6'd1}}, 1'b0, 1'b0);
    run_node('0, 1'b0, 1'b0);
    // R6: ascending and descending costs
    run_node({6'd60, 6'd50, 6'd40, 6'd30, 6'd20, 6'd10}, 1'b0, 1'b0);
    run_node({6'd5, 6'd15, 6'd25, 6'd35, 6'd45, 6'd55}, 1'b0, 1'b0);
    // R6: unique minimum on each edge in turn
    for (int p = 0; p < DEG; p++) begin
      c = {DEG{6'd42}};
      c[p*W +: W] = 6'd7;
      run_node(c, 1'b0, 1'b0);
    end
    // R2: inputs changed after acceptance
    run_node({6'd33, 6'd9, 6'd48, 6'd12, 6'd27, 6'd61}, 1'b1, 1'b0);
    // R3: start while busy
    run_node({6'd14, 6'd3, 6'd58, 6'd22, 6'd39, 6'd8}, 1'b0, 1'b1);
    // R6, R7: pseudo-random cost sets
    for (int i = 0; i < 150; i++) begin
      for (int k = 0; k < DEG; k++) begin
        lfsr = lfsr_next(lfsr);
        lfsr = lfsr_next(lfsr);
        c[k*W +: W] = lfsr[W-1:0];
      end
      run_node(c, 1'b0, 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule